// File: doc/BRIEF.md
# Chainable Serial Channel Code Loader

This block takes command words from a three-wire serial port (active-low frame enable, serial clock, serial data in) and turns each 16-bit word into a write of a 10-bit code into one of ten channel code registers. Each word also carries a refresh clock-source flag. The ten codes and the flag go to downstream refresh logic.

The serial lines are sampled by a faster system clock through two-flop synchronizers. Edge detection on the synchronized serial clock drives all shifting. A write decoded from a frame takes effect only when the enable is released.

A registered serial data output repeats the shift register's top bit after each falling serial clock edge. Several devices can therefore share one port by linking the data output of one device to the data input of the next. Every device in such a chain commits its own word on the same enable release.

Top module: `serial_code_loader`

## Requirements
- R1: While the enable is low, each rising serial clock edge shifts the data-in level into a 16-bit shift register. The first bit shifted ends at bit 15.
- R2: Word layout: bit 15 must be 0; bit 14 is the clock-source flag (0 internal, 1 external); bits 13..10 are the channel address; bits 9..0 are the code. A committed word drives the addressed code output and the flag output.
- R3: Addresses 0 to 9 select channels 0 to 9 in plain binary. A word addressed to 10 through 15 changes no code and does not change the flag.
- R4: A word with bit 15 set changes no code and does not change the flag.
- R5: Code registers and the flag change only when the enable rises. They never change while the enable is held low.
- R6: Serial clock edges while the enable is high shift nothing and do not move the data output.
- R7: A frame of fewer than 16 rising edges writes nothing. A frame of more than 16 rising edges uses only the last 16 bits.
- R8: The data output presents the shift register's bit 15 after each falling edge inside a frame. A bit shifted in appears on the data output at the 16th falling edge after it entered.
- R9: In a chain of two devices with shared enable and clock, a 32-bit frame places the first word in the second device and the second word in the first device. Both devices commit on the same enable rise.
- R10: After reset all codes are 0, the flag is 0 (internal), and the data output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rstN | input | 1 | Asynchronous active-low reset |
| selN | input | 1 | Active-low frame enable |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out for chaining |
| codes | output | NUM_CH*CODE_W | Channel codes; channel i occupies bits i*CODE_W and up |
| extClkSel | output | 1 | Clock-source flag, 1 means external |

## Verification
The bench uses the default parameters: ten channels, 10-bit codes, a 4-bit address and a 16-bit word. With a 4-bit address, the out-of-range addresses 10 to 15 can be driven, and channel 9 is the top boundary. A second instance is fed from the first one's data output. This two-device chain shows the 32-bit frame split between the devices and the shared commit.

// File: rtl/scl_pkg.sv
package scl_pkg;
  // Strobes from the control side to the datapath, one system clock wide
  typedef struct packed {
    logic shift;   // rising serial clock inside a frame
    logic fwd;     // falling serial clock inside a frame
    logic commit;  // enable released after a full word
  } strobe_t;
endpackage

// File: rtl/scl_ctrl.sv
module scl_ctrl
  import scl_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    selN,
  input  logic    sck,
  input  logic    sdi,
  output logic    sdiSync,
  output strobe_t strb
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [1:0] selPipe, sckPipe, sdiPipe;
  logic selQ, sckQ;
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selPipe <= 2'b11;
      sckPipe <= 2'b00;
      sdiPipe <= 2'b00;
      selQ    <= 1'b1;
      sckQ    <= 1'b0;
    end else begin
      selPipe <= {selPipe[0], selN};
      sckPipe <= {sckPipe[0], sck};
      sdiPipe <= {sdiPipe[0], sdi};
      selQ    <= selPipe[1];
      sckQ    <= sckPipe[1];
    end
  end

  logic selS, sckS, frameOn, sckRise, sckFall, selRise;
  assign selS    = selPipe[1];
  assign sckS    = sckPipe[1];
  assign sdiSync = sdiPipe[1];
  assign frameOn = !selS;
  assign sckRise = sckS && !sckQ;
  assign sckFall = !sckS && sckQ;
  assign selRise = selS && !selQ;

  // Count rising edges per frame, saturating at one word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else if (!frameOn && !selRise) bitCnt <= '0;
    else if (frameOn && sckRise && bitCnt != CNT_W'(WORD_W))
      bitCnt <= bitCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strb <= '0;
    else begin
      strb.shift  <= frameOn && sckRise;
      strb.fwd    <= frameOn && sckFall;
      strb.commit <= selRise && (bitCnt == CNT_W'(WORD_W));
    end
  end

  // R6: a serial clock edge and a frame release never act in the same cycle
  assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.shift, strb.fwd, strb.commit}));

  // R5: one commit per enable release
  assert_single_commit_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> !strb.commit);
endmodule

// File: rtl/scl_datapath.sv
module scl_datapath
  import scl_pkg::*;
#(
  parameter int NUM_CH = 10,
  parameter int CODE_W = 10,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strb,
  input  logic                     sdiSync,
  output logic                     sdo,
  output logic [NUM_CH*CODE_W-1:0] codes,
  output logic                     extClkSel
);
  localparam int WORD_W = CODE_W + ADDR_W + 2;
  localparam int GUARD  = WORD_W - 1;
  localparam int SELB   = WORD_W - 2;

  logic [WORD_W-1:0] shiftReg;
  logic [ADDR_W-1:0] addr;
  logic              wordOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strb.shift) shiftReg <= {shiftReg[WORD_W-2:0], sdiSync};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sdo <= 1'b0;
    else if (strb.fwd) sdo <= shiftReg[GUARD];
  end

  assign addr   = shiftReg[CODE_W +: ADDR_W];
  assign wordOk = !shiftReg[GUARD] && (int'(addr) < NUM_CH);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extClkSel <= 1'b0;
    else if (strb.commit && wordOk) extClkSel <= shiftReg[SELB];
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) codes[g*CODE_W +: CODE_W] <= '0;
      else if (strb.commit && wordOk && int'(addr) == g)
        codes[g*CODE_W +: CODE_W] <= shiftReg[CODE_W-1:0];
    end
  end

  // R5: outputs hold unless a commit strobe arrives
  assert_codes_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> ($stable(codes) && $stable(extClkSel)));

  // R4: a word with the guard bit set is dropped
  assert_guard_drop_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && shiftReg[GUARD]) |=> ($stable(codes) && $stable(extClkSel)));

  // R8: data out moves only on a falling edge inside a frame
  assert_sdo_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.fwd |=> $stable(sdo));
endmodule

// File: rtl/serial_code_loader.sv
module serial_code_loader #(
  parameter int NUM_CH = 10,
  parameter int CODE_W = 10,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     selN,
  input  logic                     sck,
  input  logic                     sdi,
  output logic                     sdo,
  output logic [NUM_CH*CODE_W-1:0] codes,
  output logic                     extClkSel
);
  localparam int WORD_W = CODE_W + ADDR_W + 2;

  scl_pkg::strobe_t strb;
  logic sdiSync;

  scl_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .selN(selN), .sck(sck), .sdi(sdi),
    .sdiSync(sdiSync), .strb(strb)
  );

  scl_datapath #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sdiSync(sdiSync),
    .sdo(sdo), .codes(codes), .extClkSel(extClkSel)
  );
endmodule

// File: tb/tb_serial_code_loader.sv
module tb_serial_code_loader;
  localparam int NUM_CH = 10;
  localparam int CODE_W = 10;

  logic clk = 0, rstN = 0, selN = 1, sck = 0, sdi = 0;
  logic sdo, ext, sdo2, ext2;
  logic [NUM_CH*CODE_W-1:0] codes, codes2;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_code_loader dut (.clk(clk), .rstN(rstN), .selN(selN), .sck(sck), .sdi(sdi),
    .sdo(sdo), .codes(codes), .extClkSel(ext));
  serial_code_loader dut2 (.clk(clk), .rstN(rstN), .selN(selN), .sck(sck), .sdi(sdo),
    .sdo(sdo2), .codes(codes2), .extClkSel(ext2));

  function automatic logic [15:0] mk(bit guard, bit ex, int addr, int code);
    return {guard, ex, 4'(addr), 10'(code)};
  endfunction

  function automatic logic [9:0] cd(int i);
    return codes[i*CODE_W +: CODE_W];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitOut(bit b);
    sdi = b; waitc(4); sck = 1; waitc(6); sck = 0; waitc(6);
  endtask

  task automatic frame(logic [31:0] data, int n);
    selN = 0; waitc(4);
    for (int i = n - 1; i >= 0; i--) bitOut(data[i]);
    waitc(4); selN = 1; waitc(10);
  endtask

  task automatic test_reset();
    for (int i = 0; i < NUM_CH; i++) chk("R10 code", 32'(cd(i)), 0);
    chk("R10 flag", 32'(ext), 0);
    chk("R10 sdo", 32'(sdo), 0);
  endtask

  task automatic test_basic();
    frame(32'(mk(0, 0, 0, 10'h3FF)), 16);
    chk("R1 ch0", 32'(cd(0)), 32'h3FF);
    chk("R2 flag internal", 32'(ext), 0);
    frame(32'(mk(0, 1, 9, 10'h200)), 16);
    chk("R3 ch9", 32'(cd(9)), 32'h200);
    chk("R2 flag external", 32'(ext), 1);
    frame(32'(mk(0, 0, 3, 10'h155)), 16);
    chk("R2 ch3", 32'(cd(3)), 32'h155);
    chk("R2 flag back", 32'(ext), 0);
    chk("R1 ch0 kept", 32'(cd(0)), 32'h3FF);
  endtask

  task automatic test_hold_low();
    selN = 0; waitc(4);
    for (int i = 15; i >= 0; i--) bitOut(mk(0, 0, 1, 10'h0AA) >> i);
    waitc(10);
    chk("R5 no write while low", 32'(cd(1)), 0);
    selN = 1; waitc(10);
    chk("R5 write on release", 32'(cd(1)), 32'h0AA);
  endtask

  task automatic test_bad_addr();
    frame(32'(mk(0, 1, 12, 10'h111)), 16);
    frame(32'(mk(0, 1, 10, 10'h111)), 16);
    chk("R3 flag kept", 32'(ext), 0);
    chk("R3 ch3 kept", 32'(cd(3)), 32'h155);
    chk("R3 ch0 kept", 32'(cd(0)), 32'h3FF);
  endtask

  task automatic test_guard();
    frame(32'(mk(1, 1, 2, 10'h0F0)), 16);
    chk("R4 ch2", 32'(cd(2)), 0);
    chk("R4 flag", 32'(ext), 0);
    chk("R8 sdo after guard word", 32'(sdo), 1);
  endtask

  task automatic test_ignore_high();
    for (int i = 0; i < 20; i++) bitOut(0);
    chk("R6 sdo unmoved", 32'(sdo), 1);
    chk("R6 ch2", 32'(cd(2)), 0);
  endtask

  task automatic test_lengths();
    frame(32'(mk(0, 0, 6, 10'h111)), 15);
    chk("R7 short frame", 32'(cd(6)), 0);
    frame({12'h0, 4'hF, mk(0, 0, 5, 10'h0AB)}, 20);
    chk("R7 long frame", 32'(cd(5)), 32'h0AB);
  endtask

  task automatic test_sdo();
    logic [31:0] data;
    int bad;
    data = {16'hA5C3, 16'h8000};
    bad = 0;
    selN = 0; waitc(4);
    for (int i = 0; i < 32; i++) begin
      bitOut(data[31-i]);
      if (i >= 15 && sdo !== data[31-(i-15)]) bad++;
    end
    waitc(4); selN = 1; waitc(10);
    chk("R8 sdo delayed by 16", 32'(bad), 0);
  endtask

  task automatic test_chain();
    frame({mk(0, 0, 4, 10'h321), mk(0, 1, 7, 10'h07C)}, 32);
    chk("R9 first word to second device", 32'(codes2[4*CODE_W +: CODE_W]), 32'h321);
    chk("R9 second word to first device", 32'(cd(7)), 32'h07C);
    chk("R9 flag first device", 32'(ext), 1);
    chk("R9 flag second device", 32'(ext2), 0);
  endtask

  initial begin
    waitc(5); rstN = 1; waitc(5);
    test_reset();
    test_basic();
    test_hold_low();
    test_bad_addr();
    test_guard();
    test_ignore_high();
    test_lengths();
    test_sdo();
    test_chain();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule